// File: doc/BRIEF.md
# Power-Domain Request Sequencer

This block performs one complete power-up or power-down request for one numbered power domain. It acts as a single-beat register-bus master toward a memory-mapped power controller. A one-cycle start pulse captures the domain number, the direction flag and a delay count. The sequencer then sets the domain's bit in the interrupt enable word and in the interrupt mask word, so the completion source is enabled but never reaches a processor. It clears any stale completion flag and confirms that the flag has cleared. Next it waits for the controller's global ready bits, submits the request and reads back the domain's rejection bit, resubmitting while the request is refused. Finally it waits for the completion flag and clears it again. Each polling loop and the retry loop has its own bound. A loop that runs past its bound ends the run at once with a distinct error code.

The states are named as follows. Idle waits for start. Enable-read and enable-write, then mask-read and mask-write, perform the two read-modify-writes. Clear-write, clear-read and clear-delay perform the flag clear, which is used twice. Ready-read and ready-delay perform the ready poll. Submit-write and reject-read perform the submission. Retry-delay spaces out resubmissions. Complete-read and complete-delay wait for the completion flag. Finish raises done.

The transitions are these:
- Each bus state advances when its transfer is acknowledged.
- Clear-read goes to ready-read after the first clear and to finish after the second.
- Ready-read goes to submit-write when the controller is ready.
- Reject-read goes to retry-delay when the request is refused and to complete-read when it is accepted.
- Complete-read goes to clear-write once the flag is seen.
- Each delay state returns to its read state when its count is used up.
- Every exhausted bound goes straight to finish.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, done, error, error code and bus request are all 0.
- R2: The domain number d selects word w = d/32 and bit d%32. The addresses are as follows: global status 0x000, flag status/clear 0x810+4w, interrupt enable 0x820+4w, interrupt mask 0x830+4w. The per-domain block starts at 0x1000+0x40·d, with power-up control at +0x4, power-down control at +0x8 and rejection status at +0xC. A bus transfer holds request, address, direction and write data until it is acknowledged.
- R3: The sequence opens with a read of the enable word, then a write of that value with the domain bit set. The mask word follows in the same way. All other bits are written back unchanged.
- R4: A flag clear writes only the domain bit to the flag word, then reads that word until the domain bit is 0. Other bits of that word are ignored. If POLL_MAX reads all show the bit set, the run ends with code 2.
- R5: Before every submission, the global status word is read until bits [1:0] are both 1. If POLL_MAX reads fail, the run ends with code 1.
- R6: A submission writes 0x1 to the power-up control word when the direction flag is 1, or to the power-down control word when it is 0. The rejection status word is read next.
- R7: Bit 0 of the rejection status set means the request was refused. The sequencer then waits, polls ready again and resubmits. Other bits of the rejection status word are ignored. The RETRY_MAX-th refusal ends the run with code 3.
- R8: After an accepted submission, the flag word is read until the domain bit is 1. If POLL_MAX reads fail, the run ends with code 4. Otherwise a second flag clear follows (R4).
- R9: Each wait between two polls or between two submissions lasts delay+1 cycles and makes no bus transfer. The delay value is the one captured at start.
- R10: Done is high for exactly one cycle at the end of a run. The error flag (code ≠ 0) and the code stay valid until the next start. A successful run reports code 0.
- R11: A start pulse during a run is ignored. Domain, direction and delay inputs that change during a run have no effect.
- R12: On any error the sequencer raises done in the next cycle and makes no further bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a run |
| dom_i | input | DOM_W | Domain number, captured at start |
| on_i | input | 1 | 1 = power up, 0 = power down, captured at start |
| dly_i | input | DLY_W | Wait length in cycles minus one, captured at start |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run ended with an error |
| err_code_o | output | 3 | 0 ok, 1 ready timeout, 2 clear timeout, 3 too many refusals, 4 completion timeout |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transfer accepted this cycle; read data valid |
| bus_rdata_i | input | 32 | Read data |

## Verification
The bench builds the block with POLL_MAX = 6 and RETRY_MAX = 3 instead of the large defaults. Every poll timeout and the refusal limit are therefore reached within a few dozen cycles, next to runs that stop one step short of each bound. Delay inputs of 0, 1 and 2 cover both the shortest wait and waits that span several cycles. Domains 0, 127 and others in between place the bit at both ends of a word and in several words.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int unsigned WORD_BITS   = 32;
    localparam int unsigned GSTAT_ADDR  = 'h000;
    localparam int unsigned FLAG_BASE   = 'h810;
    localparam int unsigned IEN_BASE    = 'h820;
    localparam int unsigned IMSK_BASE   = 'h830;
    localparam int unsigned DOM_BASE    = 'h1000;
    localparam int unsigned DOM_SHIFT   = 6;
    localparam int unsigned UP_OFS      = 'h4;
    localparam int unsigned DOWN_OFS    = 'h8;
    localparam int unsigned REJ_OFS     = 'hC;

    typedef enum logic [4:0] {
        S_IDLE,
        S_IEN_RD,
        S_IEN_WR,
        S_IMSK_RD,
        S_IMSK_WR,
        S_CLR_WR,
        S_CLR_RD,
        S_CLR_DLY,
        S_RDY_RD,
        S_RDY_DLY,
        S_SUB_WR,
        S_REJ_RD,
        S_RTY_DLY,
        S_CMP_RD,
        S_CMP_DLY,
        S_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        SEL_GSTAT,
        SEL_FLAG,
        SEL_IEN,
        SEL_IMSK,
        SEL_UP,
        SEL_DOWN,
        SEL_REJ
    } reg_sel_t;

    typedef enum logic [2:0] {
        E_NONE   = 3'd0,
        E_AGAIN  = 3'd1,
        E_CLR    = 3'd2,
        E_REJECT = 3'd3,
        E_CMPL   = 3'd4
    } err_code_t;

endpackage

// File: rtl/pwr_seq_addr.sv
module pwr_seq_addr
    import pwr_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DOM_W  = 7
) (
    input  logic [DOM_W-1:0]     dom,
    input  reg_sel_t             sel,
    output logic [ADDR_W-1:0]    addr,
    output logic [WORD_BITS-1:0] bit_mask
);
    logic [ADDR_W-1:0] word_ofs;
    logic [ADDR_W-1:0] dom_base;

    generate
        if (DOM_W > 5) begin : g_multi_word
            assign word_ofs = ADDR_W'(dom[DOM_W-1:5]) << 2;
            assign bit_mask = WORD_BITS'(1) << dom[4:0];
        end else begin : g_single_word
            assign word_ofs = '0;
            assign bit_mask = WORD_BITS'(1) << dom;
        end
    endgenerate

    assign dom_base = ADDR_W'(DOM_BASE) + (ADDR_W'(dom) << DOM_SHIFT);

    always_comb begin
        unique case (sel)
            SEL_GSTAT: addr = ADDR_W'(GSTAT_ADDR);
            SEL_FLAG:  addr = ADDR_W'(FLAG_BASE) + word_ofs;
            SEL_IEN:   addr = ADDR_W'(IEN_BASE) + word_ofs;
            SEL_IMSK:  addr = ADDR_W'(IMSK_BASE) + word_ofs;
            SEL_UP:    addr = dom_base + ADDR_W'(UP_OFS);
            SEL_DOWN:  addr = dom_base + ADDR_W'(DOWN_OFS);
            SEL_REJ:   addr = dom_base + ADDR_W'(REJ_OFS);
            default:   addr = ADDR_W'(GSTAT_ADDR);
        endcase
    end
endmodule

// File: rtl/pwr_seq_cnt.sv
module pwr_seq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int DOM_W     = 7,
    parameter int DLY_W     = 16,
    parameter int POLL_MAX  = 10000,
    parameter int RETRY_MAX = 10000,
    parameter int POLL_W    = $clog2(POLL_MAX + 1),
    parameter int RETRY_W   = $clog2(RETRY_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DOM_W-1:0]     dom_i,
    input  logic                 on_i,
    input  logic [DLY_W-1:0]     dly_i,
    input  logic                 bus_ack_i,
    input  logic [WORD_BITS-1:0] bus_rdata_i,
    input  logic [WORD_BITS-1:0] bit_mask_i,
    input  logic [POLL_W-1:0]    poll_cnt_i,
    input  logic [RETRY_W-1:0]   rty_cnt_i,
    input  logic [DLY_W-1:0]     dly_cnt_i,
    output logic [DOM_W-1:0]     dom_q,
    output reg_sel_t             sel_o,
    output logic                 bus_req_o,
    output logic                 bus_we_o,
    output logic [WORD_BITS-1:0] bus_wdata_o,
    output logic                 poll_clr_o,
    output logic                 poll_inc_o,
    output logic                 rty_clr_o,
    output logic                 rty_inc_o,
    output logic                 dly_clr_o,
    output logic                 dly_inc_o,
    output logic                 done_o,
    output logic [2:0]           err_code_o
);
    seq_state_t              state, nxt;
    logic                    on_q, second_q;
    logic [DLY_W-1:0]        dly_q;
    logic [WORD_BITS-1:0]    rmw_q;
    err_code_t               err_q, err_val;
    logic                    err_set, cap_rmw, sec_set;
    logic                    in_dly, dly_end, poll_last, rty_last;
    logic                    flag_clear, flag_set, ready, refused;

    assign in_dly     = (state == S_CLR_DLY) || (state == S_RDY_DLY) ||
                        (state == S_RTY_DLY) || (state == S_CMP_DLY);
    assign dly_end    = (dly_cnt_i == dly_q);
    assign poll_last  = (poll_cnt_i == POLL_W'(POLL_MAX - 1));
    assign rty_last   = (rty_cnt_i == RETRY_W'(RETRY_MAX - 1));
    assign flag_clear = ((bus_rdata_i & bit_mask_i) == '0);
    assign flag_set   = !flag_clear;
    assign ready      = (bus_rdata_i[1:0] == 2'b11);
    assign refused    = bus_rdata_i[0];

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            dom_q    <= '0;
            on_q     <= 1'b0;
            dly_q    <= '0;
            rmw_q    <= '0;
            second_q <= 1'b0;
            err_q    <= E_NONE;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start_i) begin
                dom_q    <= dom_i;
                on_q     <= on_i;
                dly_q    <= dly_i;
                second_q <= 1'b0;
                err_q    <= E_NONE;
            end
            if (cap_rmw) rmw_q    <= bus_rdata_i;
            if (sec_set) second_q <= 1'b1;
            if (err_set) err_q    <= err_val;
        end
    end

    // next state and counter control
    always_comb begin
        nxt        = state;
        err_set    = 1'b0;
        err_val    = E_NONE;
        cap_rmw    = 1'b0;
        sec_set    = 1'b0;
        poll_clr_o = 1'b0;
        poll_inc_o = 1'b0;
        rty_clr_o  = 1'b0;
        rty_inc_o  = 1'b0;
        dly_clr_o  = !in_dly;
        dly_inc_o  = in_dly;
        unique case (state)
            S_IDLE:    if (start_i) nxt = S_IEN_RD;
            S_IEN_RD:  if (bus_ack_i) begin cap_rmw = 1'b1; nxt = S_IEN_WR; end
            S_IEN_WR:  if (bus_ack_i) nxt = S_IMSK_RD;
            S_IMSK_RD: if (bus_ack_i) begin cap_rmw = 1'b1; nxt = S_IMSK_WR; end
            S_IMSK_WR: if (bus_ack_i) nxt = S_CLR_WR;
            S_CLR_WR:  if (bus_ack_i) begin poll_clr_o = 1'b1; nxt = S_CLR_RD; end
            S_CLR_RD: begin
                if (bus_ack_i) begin
                    if (flag_clear) begin
                        if (second_q) nxt = S_FINISH;
                        else begin
                            nxt        = S_RDY_RD;
                            poll_clr_o = 1'b1;
                            rty_clr_o  = 1'b1;
                        end
                    end else if (poll_last) begin
                        err_set = 1'b1; err_val = E_CLR; nxt = S_FINISH;
                    end else begin
                        poll_inc_o = 1'b1; nxt = S_CLR_DLY;
                    end
                end
            end
            S_CLR_DLY: if (dly_end) nxt = S_CLR_RD;
            S_RDY_RD: begin
                if (bus_ack_i) begin
                    if (ready) nxt = S_SUB_WR;
                    else if (poll_last) begin
                        err_set = 1'b1; err_val = E_AGAIN; nxt = S_FINISH;
                    end else begin
                        poll_inc_o = 1'b1; nxt = S_RDY_DLY;
                    end
                end
            end
            S_RDY_DLY: if (dly_end) nxt = S_RDY_RD;
            S_SUB_WR:  if (bus_ack_i) nxt = S_REJ_RD;
            S_REJ_RD: begin
                if (bus_ack_i) begin
                    if (!refused) begin
                        poll_clr_o = 1'b1; nxt = S_CMP_RD;
                    end else if (rty_last) begin
                        err_set = 1'b1; err_val = E_REJECT; nxt = S_FINISH;
                    end else begin
                        rty_inc_o = 1'b1; nxt = S_RTY_DLY;
                    end
                end
            end
            S_RTY_DLY: if (dly_end) begin poll_clr_o = 1'b1; nxt = S_RDY_RD; end
            S_CMP_RD: begin
                if (bus_ack_i) begin
                    if (flag_set) begin
                        sec_set = 1'b1; nxt = S_CLR_WR;
                    end else if (poll_last) begin
                        err_set = 1'b1; err_val = E_CMPL; nxt = S_FINISH;
                    end else begin
                        poll_inc_o = 1'b1; nxt = S_CMP_DLY;
                    end
                end
            end
            S_CMP_DLY: if (dly_end) nxt = S_CMP_RD;
            S_FINISH:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // bus and status outputs
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_wdata_o = '0;
        sel_o       = SEL_GSTAT;
        unique case (state)
            S_IEN_RD:  begin bus_req_o = 1'b1; sel_o = SEL_IEN; end
            S_IEN_WR:  begin bus_req_o = 1'b1; bus_we_o = 1'b1; sel_o = SEL_IEN;
                             bus_wdata_o = rmw_q | bit_mask_i; end
            S_IMSK_RD: begin bus_req_o = 1'b1; sel_o = SEL_IMSK; end
            S_IMSK_WR: begin bus_req_o = 1'b1; bus_we_o = 1'b1; sel_o = SEL_IMSK;
                             bus_wdata_o = rmw_q | bit_mask_i; end
            S_CLR_WR:  begin bus_req_o = 1'b1; bus_we_o = 1'b1; sel_o = SEL_FLAG;
                             bus_wdata_o = bit_mask_i; end
            S_CLR_RD:  begin bus_req_o = 1'b1; sel_o = SEL_FLAG; end
            S_RDY_RD:  begin bus_req_o = 1'b1; sel_o = SEL_GSTAT; end
            S_SUB_WR:  begin bus_req_o = 1'b1; bus_we_o = 1'b1;
                             sel_o = on_q ? SEL_UP : SEL_DOWN;
                             bus_wdata_o = WORD_BITS'(1); end
            S_REJ_RD:  begin bus_req_o = 1'b1; sel_o = SEL_REJ; end
            S_CMP_RD:  begin bus_req_o = 1'b1; sel_o = SEL_FLAG; end
            default:   ;
        endcase
        done_o     = (state == S_FINISH);
        err_code_o = err_q;
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_err_to_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q != E_NONE) |-> done_o);
    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state != S_IDLE) |=> $stable(dom_q) && $stable(on_q) && $stable(dly_q));
    assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt_i < POLL_W'(POLL_MAX));
    assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rty_cnt_i < RETRY_W'(RETRY_MAX));
    assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_dly |-> dly_cnt_i <= dly_q);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DOM_W     = 7,
    parameter int DLY_W     = 16,
    parameter int POLL_MAX  = 10000,
    parameter int RETRY_MAX = 10000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DOM_W-1:0]     dom_i,
    input  logic                 on_i,
    input  logic [DLY_W-1:0]     dly_i,
    output logic                 done_o,
    output logic                 err_o,
    output logic [2:0]           err_code_o,
    output logic                 bus_req_o,
    output logic                 bus_we_o,
    output logic [ADDR_W-1:0]    bus_addr_o,
    output logic [WORD_BITS-1:0] bus_wdata_o,
    input  logic                 bus_ack_i,
    input  logic [WORD_BITS-1:0] bus_rdata_i
);
    localparam int POLL_W  = $clog2(POLL_MAX + 1);
    localparam int RETRY_W = $clog2(RETRY_MAX + 1);

    logic [DOM_W-1:0]     dom_q;
    reg_sel_t             sel;
    logic [WORD_BITS-1:0] bit_mask;
    logic [POLL_W-1:0]    poll_cnt;
    logic [RETRY_W-1:0]   rty_cnt;
    logic [DLY_W-1:0]     dly_cnt;
    logic                 poll_clr, poll_inc, rty_clr, rty_inc, dly_clr, dly_inc;

    pwr_seq_fsm #(
        .DOM_W(DOM_W), .DLY_W(DLY_W), .POLL_MAX(POLL_MAX), .RETRY_MAX(RETRY_MAX),
        .POLL_W(POLL_W), .RETRY_W(RETRY_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dom_i(dom_i), .on_i(on_i),
        .dly_i(dly_i), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .bit_mask_i(bit_mask), .poll_cnt_i(poll_cnt), .rty_cnt_i(rty_cnt),
        .dly_cnt_i(dly_cnt), .dom_q(dom_q), .sel_o(sel), .bus_req_o(bus_req_o),
        .bus_we_o(bus_we_o), .bus_wdata_o(bus_wdata_o), .poll_clr_o(poll_clr),
        .poll_inc_o(poll_inc), .rty_clr_o(rty_clr), .rty_inc_o(rty_inc),
        .dly_clr_o(dly_clr), .dly_inc_o(dly_inc), .done_o(done_o),
        .err_code_o(err_code_o)
    );

    pwr_seq_addr #(.ADDR_W(ADDR_W), .DOM_W(DOM_W)) u_addr (
        .dom(dom_q), .sel(sel), .addr(bus_addr_o), .bit_mask(bit_mask)
    );

    pwr_seq_cnt #(.W(POLL_W)) u_poll_cnt (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .cnt(poll_cnt)
    );
    pwr_seq_cnt #(.W(RETRY_W)) u_rty_cnt (
        .clk(clk), .rst_n(rst_n), .clr(rty_clr), .inc(rty_inc), .cnt(rty_cnt)
    );
    pwr_seq_cnt #(.W(DLY_W)) u_dly_cnt (
        .clk(clk), .rst_n(rst_n), .clr(dly_clr), .inc(dly_inc), .cnt(dly_cnt)
    );

    assign err_o = (err_code_o != 3'd0);

    assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> bus_req_o && $stable(bus_addr_o) &&
                                       $stable(bus_we_o) && $stable(bus_wdata_o));
endmodule

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
    localparam int PM = 6;
    localparam int RM = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  dom_i = '0;
    logic        on_i = 1'b0;
    logic [7:0]  dly_i = '0;
    logic        done_o, err_o, bus_req_o, bus_we_o, bus_ack_i;
    logic [2:0]  err_code_o;
    logic [15:0] bus_addr_o;
    logic [31:0] bus_wdata_o, bus_rdata_i;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pwr_seq_top #(.ADDR_W(16), .DOM_W(7), .DLY_W(8), .POLL_MAX(PM), .RETRY_MAX(RM))
    i_pwr_seq_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dom_i(dom_i), .on_i(on_i),
        .dly_i(dly_i), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i)
    );

    // controller model
    int          s_stuck, s_rdy, s_rej, s_cmpl;
    logic [31:0] s_en, s_mk, s_bit;
    logic [15:0] a_flag, a_ien, a_imsk, a_rej;
    logic        slv_init = 1'b0;
    int          clear_left, rdy_cnt, rej_cnt, cmpl_left;
    bit          armed, flag;

    assign bus_ack_i = bus_req_o;

    always_comb begin
        bit fb;
        bus_rdata_i = 32'h0;
        if (clear_left > 0)  fb = 1'b1;
        else if (armed)      fb = (cmpl_left == 0);
        else                 fb = flag;
        if (bus_addr_o == 16'h0)
            bus_rdata_i = (rdy_cnt < s_rdy) ? 32'hF000_0001 : 32'hF000_0003;
        else if (bus_addr_o == a_flag)
            bus_rdata_i = (32'h0101_0100 & ~s_bit) | (fb ? s_bit : 32'h0);
        else if (bus_addr_o == a_ien)
            bus_rdata_i = s_en;
        else if (bus_addr_o == a_imsk)
            bus_rdata_i = s_mk;
        else if (bus_addr_o == a_rej)
            bus_rdata_i = (rej_cnt < s_rej) ? 32'h0000_0011 : 32'h0000_0010;
    end

    always @(posedge clk) begin
        if (slv_init) begin
            clear_left <= 0; rdy_cnt <= 0; rej_cnt <= 0; cmpl_left <= 0;
            armed <= 1'b0; flag <= 1'b1;
        end else if (bus_req_o) begin
            if (bus_we_o) begin
                if (bus_addr_o == a_flag) begin flag <= 1'b0; clear_left <= s_stuck; end
            end else if (bus_addr_o == a_flag) begin
                if (clear_left > 0) clear_left <= clear_left - 1;
                else if (armed) begin
                    if (cmpl_left > 0) cmpl_left <= cmpl_left - 1;
                    else begin armed <= 1'b0; flag <= 1'b1; end
                end
            end else if (bus_addr_o == 16'h0) begin
                if (rdy_cnt < s_rdy) rdy_cnt <= rdy_cnt + 1; else rdy_cnt <= 0;
            end else if (bus_addr_o == a_rej) begin
                if (rej_cnt < s_rej) rej_cnt <= rej_cnt + 1;
                else begin armed <= 1'b1; cmpl_left <= s_cmpl; end
            end
        end
    end

    // per-cycle reference: kind 0 read, 1 write, 2 quiet, 3 done
    int          q_kind[$];
    logic [15:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];

    task automatic push(int k, logic [15:0] a, logic [31:0] d, string t);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
    endtask

    task automatic push_wait(int dly);
        for (int i = 0; i <= dly; i++) push(2, 16'h0, 32'h0, "R9");
    endtask

    task automatic ref_clear(int dly, output bit bad);
        bad = 1'b0;
        push(1, a_flag, s_bit, "R2 R4");
        for (int i = 0; i < 1000; i++) begin
            push(0, a_flag, 32'h0, "R4");
            if (i >= s_stuck) break;
            if (i == PM - 1) begin push(3, 16'h0, 32'd2, "R4 R12"); bad = 1'b1; break; end
            push_wait(dly);
        end
    endtask

    task automatic build(int d, bit on, int dly);
        bit bad;
        int att;
        logic [15:0] dbase;
        dbase = 16'(32'h1000 + d * 64);
        push(0, a_ien, 32'h0, "R2 R3");
        push(1, a_ien, s_en | s_bit, "R3");
        push(0, a_imsk, 32'h0, "R2 R3");
        push(1, a_imsk, s_mk | s_bit, "R3");
        ref_clear(dly, bad);
        if (bad) return;
        att = 0;
        for (int k = 0; k < 1000; k++) begin
            for (int i = 0; i < 1000; i++) begin
                push(0, 16'h0, 32'h0, "R5");
                if (i >= s_rdy) break;
                if (i == PM - 1) begin push(3, 16'h0, 32'd1, "R5 R12"); return; end
                push_wait(dly);
            end
            push(1, on ? dbase + 16'h4 : dbase + 16'h8, 32'h1, "R2 R6");
            push(0, dbase + 16'hC, 32'h0, "R6 R7");
            if (att < s_rej) begin
                att++;
                if (att == RM) begin push(3, 16'h0, 32'd3, "R7 R12"); return; end
                push_wait(dly);
            end else break;
        end
        for (int i = 0; i < 1000; i++) begin
            push(0, a_flag, 32'h0, "R8");
            if (i >= s_cmpl) break;
            if (i == PM - 1) begin push(3, 16'h0, 32'd4, "R8 R12"); return; end
            push_wait(dly);
        end
        ref_clear(dly, bad);
        if (bad) return;
        push(3, 16'h0, 32'd0, "R10");
    endtask

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(int d, bit on, int dly, int stuck, int rdy, int rej, int cmpl,
                       logic [31:0] en, logic [31:0] mk, int poke);
        int code;
        s_stuck = stuck; s_rdy = rdy; s_rej = rej; s_cmpl = cmpl; s_en = en; s_mk = mk;
        s_bit  = 32'h1 << (d % 32);
        a_flag = 16'(32'h810 + 4 * (d / 32));
        a_ien  = 16'(32'h820 + 4 * (d / 32));
        a_imsk = 16'(32'h830 + 4 * (d / 32));
        a_rej  = 16'(32'h1000 + d * 64 + 12);
        q_kind.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
        build(d, on, dly);
        slv_init = 1'b1;
        @(negedge clk);
        slv_init = 1'b0;
        dom_i = 7'(d); on_i = on; dly_i = 8'(dly); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        code = 0;
        foreach (q_kind[idx]) begin
            logic [63:0] act, exp;
            bit ok;
            act = {8'h0, 1'b0, bus_req_o, bus_we_o, done_o, 1'b0, err_code_o,
                   bus_addr_o, bus_wdata_o};
            case (q_kind[idx])
                0: begin
                    ok = bus_req_o && !bus_we_o && !done_o && bus_addr_o == q_addr[idx];
                    exp = {8'h0, 4'b0100, 1'b0, err_code_o, q_addr[idx], bus_wdata_o};
                end
                1: begin
                    ok = bus_req_o && bus_we_o && !done_o && bus_addr_o == q_addr[idx] &&
                         bus_wdata_o == q_data[idx];
                    exp = {8'h0, 4'b0110, 1'b0, err_code_o, q_addr[idx], q_data[idx]};
                end
                2: begin
                    ok = !bus_req_o && !done_o;
                    exp = {8'h0, 4'b0000, 1'b0, err_code_o, bus_addr_o, bus_wdata_o};
                end
                default: begin
                    code = int'(q_data[idx]);
                    ok = done_o && !bus_req_o && err_code_o == q_data[idx][2:0] &&
                         err_o == (code != 0);
                    exp = {8'h0, 4'b0001, 1'b0, q_data[idx][2:0], bus_addr_o, bus_wdata_o};
                end
            endcase
            chk(ok, q_tag[idx], act, exp);
            if (idx == poke) begin
                start_i = 1'b1; dom_i = 7'd3; on_i = ~on; dly_i = 8'd0;
            end else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        // R10: one-cycle done, code held; R12: no further transfers
        for (int c = 0; c < 3; c++) begin
            chk(!done_o && !bus_req_o && err_code_o == 3'(code) && err_o == (code != 0),
                "R10 R12 after done", {59'h0, done_o, bus_req_o, err_code_o},
                {59'h0, 1'b0, 1'b0, 3'(code)});
            @(negedge clk);
        end
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        chk(!done_o && !err_o && err_code_o == 3'd0 && !bus_req_o, "R1 reset",
            {60'h0, done_o, err_o, bus_req_o, 1'b0}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !bus_req_o, "R1 idle", {62'h0, done_o, bus_req_o}, 64'h0);
        // R3 R8 plain success
        run(37, 1'b1, 1, 0, 0, 0, 2, 32'h0000_1000, 32'hFFFF_0000, -1);
        // R4 R5 R7 stuck clear, busy ready, two refusals
        run(0, 1'b0, 0, 2, 1, 2, 0, 32'h8000_0000, 32'h0, -1);
        // R7 refusal limit
        run(127, 1'b1, 2, 0, 0, 3, 0, 32'h0, 32'h1234_5678, -1);
        // R5 ready timeout
        run(64, 1'b0, 0, 0, 100, 0, 0, 32'h0, 32'h0, -1);
        // R4 clear timeout
        run(95, 1'b1, 1, 100, 0, 0, 0, 32'h5, 32'h0, -1);
        // R8 completion timeout
        run(5, 1'b0, 1, 0, 0, 0, 100, 32'h0, 32'h0, -1);
        // R8 last poll succeeds, R11 start during run, code back to 0
        run(37, 1'b1, 1, 1, 2, 1, PM - 1, 32'h0, 32'h0, 10);
        // R11 start at the very first cycle of a run
        run(70, 1'b0, 0, 0, 0, 0, 0, 32'hAAAA_0000, 32'h0, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", 64'h0, 64'h1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule